// File: doc/BRIEF.md
# Page Write Buffer Controller

This block is the write side of a serial-bus memory device. Its bus front end decodes the bus signalling. The front end hands the block a 16-bit byte address, a write-protect sample strobe, the data bytes one at a time, and a STOP indication. The block keeps the page part of the address fixed and gathers the data bytes into a page-sized holding buffer. It steps only the offset within the page, and that offset wraps at the page end. Nothing reaches the storage array while the bytes arrive.

When the transaction ends with STOP and at least one byte was accepted, the block opens a timed internal write cycle. It holds `busy` high for a fixed number of clocks, and the front end uses that flag to refuse new addressing attempts so the master can poll. Early in that window the block walks the buffer once and drives one array write for every buffered entry. The write-protect pin is sampled once per transaction, at the strobe that comes just before the first data byte. If the pin is high at that instant, the data bytes are refused and the transaction is dropped.

A current-address register follows the loaded address and, after a commit, points one past the last byte written, wrapping inside the page.

Top module: `page_write_ctrl`

## Requirements
- R1: While reset is asserted and directly after it, `busy`, `arr_we` and `data_nack` are 0 and `cur_addr` is 0.
- R2: On `addr_load`, bits [15:12] of `addr_in` are ignored. Bits [11:5] become the page and bits [4:0] become the start offset. `cur_addr` equals `addr_in[11:0]` one clock later.
- R3: Each accepted data byte is stored at offset, then offset increments by one. All array writes of one commit use the latched page in `arr_addr[11:5]`.
- R4: The offset wraps from 31 to 0 inside the same page. A byte that lands on an offset already filled in the same transaction replaces the earlier byte.
- R5: No array write occurs before STOP. A `stop_seen` with at least one accepted byte raises `busy` on the next clock for exactly WR_CYCLES clocks. `arr_we` is high only while `busy` is high.
- R6: During the busy window, each filled offset is written exactly once with its latest byte, and no other array address is written.
- R7: While `busy` is high, `addr_load`, `byte_valid` and `stop_seen` have no effect. They change neither `cur_addr` nor the buffer, and they start no further write cycle.
- R8: `wp_in` is sampled only on `wp_strobe`. If it was 1 there, `data_nack` is 1 until STOP, all bytes are discarded, and STOP opens no write cycle. `wp_in` changes at any other time have no effect.
- R9: A `stop_seen` after `addr_load` with no accepted data byte leaves `busy` low and writes nothing.
- R10: When the write cycle ends, `cur_addr` equals {page, offset after the last accepted byte}. When no write cycle runs, `cur_addr` keeps the loaded address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_load | input | 1 | Pulse: both address bytes of a write request received |
| addr_in | input | 16 | Received byte address; top four bits ignored |
| wp_in | input | 1 | Write-protect pin level |
| wp_strobe | input | 1 | Pulse at the last SCL fall before the first data byte |
| byte_valid | input | 1 | Pulse: one data byte received |
| byte_data | input | 8 | Data byte |
| stop_seen | input | 1 | Pulse: STOP condition detected |
| data_nack | output | 1 | Data bytes of this request must not be acknowledged |
| busy | output | 1 | Internal write cycle in progress; refuse addressing |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 12 | Array write address |
| arr_wdata | output | 8 | Array write data |
| cur_addr | output | 12 | Current-address register |

## Verification
Write requests run with 0 to 40 data bytes at random start offsets and random gaps between bytes. Short runs show that the offset steps correctly. Runs past 32 bytes starting near the page end tell the wrap-and-overwrite path apart from a carry into the page bits. A high protect level at the strobe that is then toggled separates the single sample point from a level-sensitive check. Pulses of the address, data and STOP inputs during the busy window, and a STOP with no data, show that neither starts a write cycle or moves the current address.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  typedef enum logic [1:0] {
    PW_IDLE   = 2'd0,
    PW_FILL   = 2'd1,
    PW_COMMIT = 2'd2
  } pw_state_e;
endpackage

// File: rtl/pwb_page_buf.sv
// Page-sized holding buffer with a per-entry fill mask.
module pwb_page_buf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_vld,
  output logic              any_vld
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [DEPTH-1:0]  vld_q, vld_d;

  // Data entries carry no reset: the fill mask qualifies every read.
  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (wr_en && (wr_idx == IDX_W'(g))) begin
        mem_q[g] <= wr_data;
      end
    end
  end

  always_comb begin
    vld_d = vld_q;
    if (clr) begin
      vld_d = '0;
    end else if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_data = mem_q[rd_idx];
  assign rd_vld  = vld_q[rd_idx];
  assign any_vld = |vld_q;
endmodule

// File: rtl/pwb_cycle_timer.sv
// Fixed-length write window; the first WALK clocks index the buffer.
module pwb_cycle_timer #(
  parameter int CYCLES = 64,
  parameter int WALK   = 32,
  localparam int CNT_W = $clog2(CYCLES),
  localparam int IDX_W = $clog2(WALK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             running,
  output logic             walk,
  output logic [IDX_W-1:0] walk_idx,
  output logic             done
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign done = run_q && (cnt_q == LAST);

  always_comb begin
    run_d = run_q;
    cnt_d = cnt_q;
    if (start && !run_q) begin
      run_d = 1'b1;
      cnt_d = '0;
    end else if (run_q) begin
      if (done) run_d = 1'b0;
      else      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      cnt_q <= cnt_d;
    end
  end

  assign running  = run_q;
  assign walk     = run_q && (cnt_q < CNT_W'(WALK));
  assign walk_idx = cnt_q[IDX_W-1:0];
endmodule

// File: rtl/page_write_ctrl.sv
module page_write_ctrl
  import pwb_pkg::*;
#(
  parameter int BUS_ADDR_W = 16,
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 500000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  addr_load,
  input  logic [BUS_ADDR_W-1:0] addr_in,
  input  logic                  wp_in,
  input  logic                  wp_strobe,
  input  logic                  byte_valid,
  input  logic [DATA_W-1:0]     byte_data,
  input  logic                  stop_seen,
  output logic                  data_nack,
  output logic                  busy,
  output logic                  arr_we,
  output logic [ADDR_W-1:0]     arr_addr,
  output logic [DATA_W-1:0]     arr_wdata,
  output logic [ADDR_W-1:0]     cur_addr
);
  localparam int OFF_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFF_W;

  pw_state_e          state_q, state_d;
  logic [PAGE_W-1:0]  page_q, page_d;
  logic [OFF_W-1:0]   off_q, off_d;
  logic               rej_q, rej_d;
  logic [ADDR_W-1:0]  cur_q, cur_d;

  logic               load_ok, take_byte, commit_go, buf_clr;
  logic               any_vld, rd_vld, walk, done, running;
  logic [OFF_W-1:0]   walk_idx;
  logic [DATA_W-1:0]  rd_data;
  logic               unused_addr_hi;

  assign unused_addr_hi = ^addr_in[BUS_ADDR_W-1:ADDR_W];

  assign load_ok   = addr_load && (state_q != PW_COMMIT);
  assign take_byte = (state_q == PW_FILL) && byte_valid && !rej_q;
  assign commit_go = (state_q == PW_FILL) && stop_seen && any_vld && !rej_q;
  assign buf_clr   = load_ok || done;

  always_comb begin
    state_d = state_q;
    page_d  = page_q;
    off_d   = off_q;
    rej_d   = rej_q;
    cur_d   = cur_q;
    unique case (state_q)
      PW_IDLE: ;
      PW_FILL: begin
        if (wp_strobe) rej_d = wp_in;
        if (take_byte) off_d = off_q + 1'b1;
        if (stop_seen) state_d = commit_go ? PW_COMMIT : PW_IDLE;
      end
      PW_COMMIT: begin
        if (done) begin
          state_d = PW_IDLE;
          cur_d   = {page_q, off_q};
        end
      end
      default: state_d = PW_IDLE;
    endcase
    if (load_ok) begin
      state_d = PW_FILL;
      page_d  = addr_in[ADDR_W-1:OFF_W];
      off_d   = addr_in[OFF_W-1:0];
      rej_d   = 1'b0;
      cur_d   = addr_in[ADDR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_IDLE;
      page_q  <= '0;
      off_q   <= '0;
      rej_q   <= 1'b0;
      cur_q   <= '0;
    end else begin
      state_q <= state_d;
      page_q  <= page_d;
      off_q   <= off_d;
      rej_q   <= rej_d;
      cur_q   <= cur_d;
    end
  end

  pwb_page_buf #(.DATA_W(DATA_W), .DEPTH(PAGE_BYTES)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (buf_clr),
    .wr_en   (take_byte),
    .wr_idx  (off_q),
    .wr_data (byte_data),
    .rd_idx  (walk_idx),
    .rd_data (rd_data),
    .rd_vld  (rd_vld),
    .any_vld (any_vld)
  );

  pwb_cycle_timer #(.CYCLES(WR_CYCLES), .WALK(PAGE_BYTES)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (commit_go),
    .running  (running),
    .walk     (walk),
    .walk_idx (walk_idx),
    .done     (done)
  );

  assign busy      = running;
  assign data_nack = (state_q == PW_FILL) && rej_q;
  assign arr_we    = walk && rd_vld;
  assign arr_addr  = {page_q, walk_idx};
  assign arr_wdata = rd_data;
  assign cur_addr  = cur_q;
endmodule

// File: rtl/pwb_chk.sv
module pwb_chk #(
  parameter int ADDR_W     = 12,
  parameter int PAGE_BYTES = 32,
  parameter int WR_CYCLES  = 64,
  localparam int OFF_W     = $clog2(PAGE_BYTES)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stop_seen,
  input logic              data_nack,
  input logic              busy,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic [ADDR_W-1:0] cur_addr
);
  int unsigned len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    len_q <= 0;
    else if (busy) len_q <= len_q + 1;
    else           len_q <= 0;
  end

  // R5
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);

  // R5
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_seen));

  // R5
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (len_q == WR_CYCLES));

  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_addr));

  // R8
  nack_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_nack && stop_seen) |=> !busy);

  // R3
  page_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_we && $past(arr_we)) |->
      (arr_addr[ADDR_W-1:OFF_W] == $past(arr_addr[ADDR_W-1:OFF_W])));
endmodule

bind page_write_ctrl pwb_chk #(
  .ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .stop_seen (stop_seen),
  .data_nack (data_nack),
  .busy      (busy),
  .arr_we    (arr_we),
  .arr_addr  (arr_addr),
  .cur_addr  (cur_addr)
);

// File: tb/page_write_ctrl_test.sv
module page_write_ctrl_test;
  localparam int WR = 48;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        addr_load, wp_in, wp_strobe, byte_valid, stop_seen;
  logic [15:0] addr_in;
  logic [7:0]  byte_data;
  logic        data_nack, busy, arr_we;
  logic [11:0] arr_addr, cur_addr;
  logic [7:0]  arr_wdata;

  int checks = 0;
  int fails  = 0;
  int cap_n  = 0;
  logic [11:0] cap_a [64];
  logic [7:0]  cap_d [64];
  logic [7:0]  exp_d [32];
  logic [31:0] exp_v;

  page_write_ctrl #(.WR_CYCLES(WR)) uut (
    .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .addr_in(addr_in),
    .wp_in(wp_in), .wp_strobe(wp_strobe), .byte_valid(byte_valid),
    .byte_data(byte_data), .stop_seen(stop_seen), .data_nack(data_nack),
    .busy(busy), .arr_we(arr_we), .arr_addr(arr_addr),
    .arr_wdata(arr_wdata), .cur_addr(cur_addr)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (arr_we) begin
      if (cap_n < 64) begin
        cap_a[cap_n] = arr_addr;
        cap_d[cap_n] = arr_wdata;
      end
      cap_n = cap_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int popc(input logic [31:0] v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += int'(v[i]);
    return c;
  endfunction

  task automatic run_txn(input logic [15:0] a, input int n, input bit wp, input bit poke);
    logic [6:0]  page = a[11:5];
    logic [4:0]  off  = a[4:0];
    logic [31:0] seen = '0;
    bit          want = (n > 0) && !wp;
    int          len;
    bit          ok;
    exp_v = '0;
    @(negedge clk); addr_in = a; addr_load = 1'b1;
    @(negedge clk); addr_load = 1'b0; cap_n = 0;
    chk(cur_addr == a[11:0], "R2 address load", int'(cur_addr), int'(a[11:0]));
    if (n > 0) begin
      wp_in = wp; wp_strobe = 1'b1;
      @(negedge clk); wp_strobe = 1'b0; wp_in = ~wp;
      chk(data_nack == wp, "R8 protect sample", int'(data_nack), int'(wp));
      for (int i = 0; i < n; i++) begin
        byte_data = 8'($urandom); byte_valid = 1'b1;
        if (!wp) begin
          exp_d[off] = byte_data; exp_v[off] = 1'b1; off = off + 1'b1;
        end
        @(negedge clk); byte_valid = 1'b0;
        repeat ($urandom % 3) @(negedge clk);
      end
    end
    chk(cap_n == 0 && !busy, "R5 nothing before STOP", cap_n, 0);
    stop_seen = 1'b1;
    @(negedge clk); stop_seen = 1'b0; wp_in = 1'b0;
    chk(busy == want, want ? "R5 busy on STOP" : (wp ? "R8 no cycle" : "R9 no cycle"),
        int'(busy), int'(want));
    if (want) begin
      len = 1;
      if (poke) begin
        addr_in = a ^ 16'h0fff; addr_load = 1'b1;
        @(negedge clk); addr_load = 1'b0; byte_valid = 1'b1; len++;
        @(negedge clk); byte_valid = 1'b0; stop_seen = 1'b1; len++;
        @(negedge clk); stop_seen = 1'b0; len++;
      end
      while (busy) begin
        @(negedge clk);
        if (busy) len++;
      end
      chk(len == WR, "R5 window length", len, WR);
    end
    chk(cap_n == popc(exp_v), "R6 write count", cap_n, popc(exp_v));
    for (int k = 0; k < cap_n && k < 64; k++) begin
      ok = (cap_a[k][11:5] == page) && exp_v[cap_a[k][4:0]] &&
           !seen[cap_a[k][4:0]] && (cap_d[k] == exp_d[cap_a[k][4:0]]);
      seen[cap_a[k][4:0]] = 1'b1;
      chk(ok, (n > 32) ? "R4 wrapped content" : "R3 page content",
          int'({cap_a[k], cap_d[k]}), int'({page, cap_a[k][4:0], exp_d[cap_a[k][4:0]]}));
    end
    chk(cur_addr == (want ? {page, off} : a[11:0]), "R10 current address",
        int'(cur_addr), int'(want ? {page, off} : a[11:0]));
    if (poke) begin
      byte_valid = 1'b1;
      @(negedge clk); byte_valid = 1'b0; stop_seen = 1'b1;
      @(negedge clk); stop_seen = 1'b0;
      @(negedge clk);
      chk(!busy && cap_n == popc(exp_v) && cur_addr == {page, off},
          "R7 busy-time inputs ignored", int'(busy), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    rst_n = 1'b0; addr_load = 0; addr_in = '0; wp_in = 0; wp_strobe = 0;
    byte_valid = 0; byte_data = '0; stop_seen = 0;
    repeat (3) @(negedge clk);
    chk(!busy && !arr_we && !data_nack && cur_addr == 0, "R1 reset state",
        int'({busy, arr_we, data_nack}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !arr_we && cur_addr == 0, "R1 after release", int'(cur_addr), 0);
    run_txn(16'hF3A5, 5, 1'b0, 1'b0);
    run_txn(16'h007E, 40, 1'b0, 1'b0);
    run_txn(16'h0100, 3, 1'b1, 1'b0);
    run_txn(16'h0200, 0, 1'b0, 1'b0);
    run_txn(16'h0ABC, 4, 1'b0, 1'b1);
    for (int t = 0; t < 15; t++) begin
      run_txn(16'($urandom), int'($urandom % 41), ($urandom % 5) == 0, 1'($urandom));
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule